// File: doc/BRIEF.md
# Single-Sense Keypad Scanner with Short Key Strobe

This block scans a matrix of 32 switches that all share one common, active-low sense return. A counter steps through the keys in a fixed order. Each key owns one scan slot of eight sub-steps. The key's drive line is raised only during the first sub-step of its slot. The remaining seven sub-steps leave the line undriven. A slow, filtered sense line can therefore settle and then return to idle before the next key is driven. A late sense response cannot be credited to the wrong key.

The raw sense input is first brought into the clock domain by a two-flop synchronizer. It is sampled once per slot, on the final clock of a chosen sub-step, and the result is credited to the key that owns the slot. A 32-bit state register remembers which keys are held down. When a sample disagrees with the stored state, the register is updated and a single-cycle event reports the key index and whether the key went down or came up. The length of a sub-step in clocks is a parameter, so the slot can be stretched to suit the recovery time of the external filter.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is high, and on the first clock after it, every strobe bit is 0 and no event is raised. After reset every key is treated as released, so a key held through reset is reported again as a press.
- R2: At most one bit of `strobe` is 1 in any cycle.
- R3: Successive strobe pulses select keys 0, 1, 2, … 31 in ascending order, then wrap back to 0.
- R4: Each strobe pulse lasts exactly `STEP_CLKS` clocks, which is one eighth of a slot. Consecutive pulses are separated by `7*STEP_CLKS` idle clocks.
- R5: `sense_n` is active low. A key is taken as pressed when the synchronized sense level is 0 on the last clock of sub-step `SAMPLE_STEP` of that key's slot. It is taken as released when that level is 1.
- R6: An event is a one-cycle pulse on `evt_valid`. No two events occur in adjacent cycles. `evt_key` gives the index of the key whose slot produced the sample. `evt_pressed` is 1 for a press and 0 for a release.
- R7: No event is raised while a key's sampled level matches its stored state. After every key in a new pattern has been scanned, the number of events equals the number of keys whose state changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_n | input | 1 | Raw shared sense line, low while a driven key is closed |
| strobe | output | 32 | One-hot key drive, bit i drives key i |
| evt_valid | output | 1 | One-cycle key event pulse |
| evt_key | output | 5 | Index of the key that changed |
| evt_pressed | output | 1 | 1 = key went down, 0 = key came up |

## Verification
The assertions assume two things about `sense_n`. First, any low level it shows during a slot is caused by that slot's own strobe. Second, the line is back at its idle high level before the next key is strobed. Under these conditions, each sampled level and each event belong to the key whose slot is running.

The bench's matrix model follows these conditions. It pulls the line low only while a strobe hits a closed key, and then holds it low for a fixed stretch. That stretch ends after the sample point and well before the next strobe. Key patterns are compared with the event stream only after two full scans have passed. This way a pattern change that lands in the middle of a slot can delay a report but never garble it.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
    localparam int KEYS      = 32;
    localparam int KEY_W     = $clog2(KEYS);
    localparam int SUB_W     = 3;
    localparam int SUBS      = 1 << SUB_W;
    localparam int GROUP     = 8;
    localparam int GROUP_W   = $clog2(GROUP);
    localparam int GROUPS    = KEYS / GROUP;
    localparam int GSEL_W    = KEY_W - GROUP_W;

    // scan position: upper bits pick the key, lower bits the sub-step
    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [SUB_W-1:0] sub;
    } scan_pos_t;

    typedef struct packed {
        logic             valid;
        logic [KEY_W-1:0] key;
        logic             pressed;
    } key_evt_t;

    function automatic logic [GROUP-1:0] line_decode(input logic [GROUP_W-1:0] sel);
        logic [GROUP-1:0] v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/kscan_timer.sv
module kscan_timer
    import kscan_pkg::*;
#(
    parameter int STEP_CLKS = 4
) (
    input  logic      clk,
    input  logic      rst,
    output scan_pos_t pos_o,
    output logic      step_end_o
);
    localparam int PW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;

    logic [PW-1:0] pre_q;
    scan_pos_t     pos_q;

    assign step_end_o = (pre_q == PW'(STEP_CLKS - 1));
    assign pos_o      = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            pos_q <= '0;
        end else if (step_end_o) begin
            pre_q <= '0;
            pos_q <= scan_pos_t'(pos_q + 1'b1);
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R3
    key_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step_end_o && pos_q.sub == '1) |=> (pos_q.key == KEY_W'($past(pos_q.key) + 1'b1)));
endmodule

// File: rtl/kscan_strobe.sv
module kscan_strobe
    import kscan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  scan_pos_t       pos_i,
    output logic [KEYS-1:0] strobe_o
);
    logic [KEYS-1:0] strobe_d;
    logic [KEYS-1:0] strobe_q;

    // one decoder per group of eight lines, enabled by group select and sub-step 0
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic grp_en;
        assign grp_en = (pos_i.sub == '0) &&
                        (pos_i.key[KEY_W-1:GROUP_W] == GSEL_W'(g));
        assign strobe_d[g*GROUP +: GROUP] =
            grp_en ? line_decode(pos_i.key[GROUP_W-1:0]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= '0;
        else     strobe_q <= strobe_d;
    end

    assign strobe_o = strobe_q;

    // R2
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_q));
    // R4
    strobe_window_chk: assert property (@(posedge clk) disable iff (rst)
        (|strobe_d) |-> (pos_i.sub == '0));
    // R1
    strobe_reset_chk: assert property (@(posedge clk)
        rst |=> (strobe_q == '0));
endmodule

// File: rtl/kscan_sync.sv
module kscan_sync #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic s1_q;
    logic s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= IDLE;
            s2_q <= IDLE;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/kscan_tracker.sv
module kscan_tracker
    import kscan_pkg::*;
#(
    parameter int SAMPLE_STEP = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  scan_pos_t pos_i,
    input  logic      step_end_i,
    input  logic      sense_n_i,
    output key_evt_t  evt_o
);
    logic [KEYS-1:0] held_q;
    key_evt_t        evt_q;
    logic            sample;
    logic            hit;

    assign sample = step_end_i && (pos_i.sub == SUB_W'(SAMPLE_STEP));
    assign hit    = ~sense_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            evt_q  <= '0;
        end else if (sample && (hit != held_q[pos_i.key])) begin
            held_q[pos_i.key] <= hit;
            evt_q.valid       <= 1'b1;
            evt_q.key         <= pos_i.key;
            evt_q.pressed     <= hit;
        end else begin
            evt_q.valid <= 1'b0;
        end
    end

    assign evt_o = evt_q;

    // R6
    evt_single_chk: assert property (@(posedge clk) disable iff (rst)
        evt_q.valid |=> !evt_q.valid);
    // R6
    evt_from_sample_chk: assert property (@(posedge clk) disable iff (rst)
        evt_q.valid |-> ($past(sample) && evt_q.key == $past(pos_i.key)));
    // R5
    evt_level_chk: assert property (@(posedge clk) disable iff (rst)
        evt_q.valid |-> (evt_q.pressed == !$past(sense_n_i)));
    // R1
    evt_reset_chk: assert property (@(posedge clk)
        rst |=> !evt_q.valid);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kscan_pkg::*;
#(
    parameter int STEP_CLKS   = 4,
    parameter int SAMPLE_STEP = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sense_n,
    output logic [31:0] strobe,
    output logic        evt_valid,
    output logic [4:0]  evt_key,
    output logic        evt_pressed
);
    scan_pos_t pos;
    logic      step_end;
    logic      sense_sync_n;
    key_evt_t  evt;

    kscan_timer #(.STEP_CLKS(STEP_CLKS)) u_timer (
        .clk(clk), .rst(rst), .pos_o(pos), .step_end_o(step_end)
    );

    kscan_strobe u_strobe (
        .clk(clk), .rst(rst), .pos_i(pos), .strobe_o(strobe)
    );

    kscan_sync #(.IDLE(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d_i(sense_n), .q_o(sense_sync_n)
    );

    kscan_tracker #(.SAMPLE_STEP(SAMPLE_STEP)) u_track (
        .clk(clk), .rst(rst), .pos_i(pos), .step_end_i(step_end),
        .sense_n_i(sense_sync_n), .evt_o(evt)
    );

    assign evt_valid   = evt.valid;
    assign evt_key     = evt.key;
    assign evt_pressed = evt.pressed;
endmodule

// File: tb/keypad_scanner_tb.sv
module keypad_scanner_tb;
    localparam int STEP = 4;
    localparam int SCAN = 32 * 8 * STEP;
    localparam int HOLD = 16;
    localparam int NPAT = 6;
    localparam logic [31:0] PATS [NPAT] = '{
        32'h0000_0001, 32'h8000_0001, 32'hFFFF_FFFF,
        32'h0000_0000, 32'hA5A5_0F0F, 32'h5A5A_F0F0
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sense_n;
    logic [31:0] strobe;
    logic        evt_valid;
    logic [4:0]  evt_key;
    logic        evt_pressed;

    logic [31:0] down = '0;
    int          hold_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          clocks = 0;
    bit          done = 0;

    // monitor state
    logic [31:0] model = '0;
    int          evt_count = 0;
    int          v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r6 = 0;
    bit          have_prev = 0, in_pulse = 0, prev_evt = 0;
    int          prev_idx = 0, run = 0, gap = 0;

    always #2 clk = ~clk;

    keypad_scanner u_dut (
        .clk(clk), .rst(rst), .sense_n(sense_n), .strobe(strobe),
        .evt_valid(evt_valid), .evt_key(evt_key), .evt_pressed(evt_pressed)
    );

    // matrix with a slow return: low while a closed key is driven, then held
    always @(posedge clk) begin
        if (|(strobe & down)) hold_cnt <= HOLD;
        else if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
    end
    assign sense_n = !((hold_cnt > 0) || (|(strobe & down)));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            model = '0; have_prev = 0; in_pulse = 0; prev_evt = 0; run = 0; gap = 0;
        end else begin
            if ($countones(strobe) > 1) v_r2++;
            if (strobe != '0) begin
                if (!in_pulse) begin
                    int idx = 0;
                    for (int i = 0; i < 32; i++) if (strobe[i]) idx = i;
                    if (have_prev) begin
                        if (idx != (prev_idx + 1) % 32) v_r3++;
                        if (gap != 7 * STEP) v_r4++;
                    end
                    prev_idx = idx; have_prev = 1; in_pulse = 1; run = 0;
                end
                run++;
            end else begin
                if (in_pulse) begin
                    if (run != STEP) v_r4++;
                    in_pulse = 0; gap = 0;
                end
                gap++;
            end
            if (evt_valid) begin
                if (prev_evt) v_r6++;
                if (evt_pressed == model[evt_key]) v_r6++;
                if (have_prev && evt_key != 5'(prev_idx)) v_r6++;
                model[evt_key] = evt_pressed;
                evt_count++;
            end
            prev_evt = evt_valid;
        end
    end

    always @(posedge clk) begin
        clocks <= clocks + 1;
        if (clocks > 150000 && !done) begin
            done = 1;
            check(0, "WDOG", "watchdog expired", clocks, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(strobe == '0, "R1", "strobe in reset", strobe, 0);
        check(!evt_valid, "R1", "event in reset", evt_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(strobe == 32'h1, "R1", "first strobe after reset is key 0", strobe, 1);

        prev = '0;
        for (int p = 0; p < NPAT; p++) begin
            evt_count = 0;
            down = PATS[p];
            repeat (2 * SCAN + 100) @(posedge clk);
            @(negedge clk);
            // R5: reported states match the closed keys
            check(model == PATS[p], "R5", "key map after scans", model, PATS[p]);
            // R7: one event per changed key
            check(evt_count == $countones(prev ^ PATS[p]), "R7", "event count",
                  evt_count, $countones(prev ^ PATS[p]));
            evt_count = 0;
            repeat (SCAN) @(posedge clk);
            @(negedge clk);
            check(evt_count == 0, "R7", "events with steady keys", evt_count, 0);
            prev = PATS[p];
        end

        // R1: key held through reset is reported again as a press
        down = 32'h0000_0010;
        repeat (2 * SCAN) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(strobe == '0 && !evt_valid, "R1", "outputs during mid-run reset", strobe, 0);
        evt_count = 0;
        rst = 1'b0;
        repeat (SCAN + 100) @(posedge clk);
        @(negedge clk);
        check(evt_count == 1 && model == 32'h10, "R1", "press re-reported after reset",
              evt_count, 1);

        check(v_r2 == 0, "R2", "multi-bit strobe cycles", v_r2, 0);
        check(v_r3 == 0, "R3", "strobe order violations", v_r3, 0);
        check(v_r4 == 0, "R4", "strobe width/gap violations", v_r4, 0);
        check(v_r6 == 0, "R6", "event form violations", v_r6, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule